// File: doc/BRIEF.md
# Transceiver Reconfiguration Request Controller

This block sits between a local link controller and a transceiver reconfiguration engine. The controller asks for one of three kinds of change: a new PCS operating mode, a CTLE update, or a run of the RX decision-feedback equalizer. Each request is a single-cycle pulse together with its fields. The block checks the fields and parks an accepted request in a pending slot for its kind. It then issues the pending requests to the engine one at a time, with a start strobe and a handshake on the engine's busy line.

Each kind has one pending slot. When the handshake machine is idle, a fixed-priority picker chooses among the pending kinds. The handshake machine has three states. **IDLE** waits for work. In **ISSUE** the start strobe of the granted kind is high. In **HOLD** the strobe is low and the fields stay frozen. The transitions are:
- *grant*: IDLE to ISSUE, when any slot is pending.
- *ack*: ISSUE to HOLD, when busy is sampled high.
- *release*: HOLD to IDLE, when busy is sampled low.

The field outputs for a kind are loaded only on the *grant* edge for that kind, so they cannot change while a request is outstanding. A PCS request may ask for a data mode instead of naming a mode. With automatic speed detection off, the mode then comes from a static 1G/10G select input.

Top module: `xcvr_reconf_ctrl`

## Requirements
- R1: After reset, all three start strobes and `req_err` are low. `pcs_mode_o` is 6'b000001 (auto-negotiation), `dfe_mode_o` is 2'b00 (DFE off), and the CTLE outputs are zero.
- R2: A PCS request is accepted only if the resolved mode has exactly one bit set and that bit is not bit 4. The mode bits are: bit 0 auto-negotiation, bit 1 link training, bit 2 10GBASE-KR data, bit 3 GigE data, bit 4 reserved, bit 5 10G data with FEC.
- R3: A DFE request is accepted for mode 2'b00 (off) and 2'b01 (triggered). Modes 2'b10 and 2'b11 are rejected.
- R4: A CTLE request is accepted only for mode 2'b00 (apply the link-training value). It then carries any 4-bit value from 0 to 15. Modes 2'b01, 2'b10 and 2'b11 are rejected.
- R5: A rejected request drives `req_err` high for exactly the one cycle after its capture edge. It raises no strobe and leaves every field output unchanged.
- R6: With `pcs_use_speed` high and `autodet_en` low, the mode is 6'b001000 if `sel_1g` is high and 6'b000100 if it is low. With `autodet_en` high, `pcs_mode_in` is used unchanged.
- R7: On an idle machine, an accepted request raises its strobe on the second rising edge after the request pulse. The fields of that kind load on the same edge.
- R8: A strobe stays high until busy is sampled high, and is low from the following cycle.
- R9: The field outputs do not change from the strobe's rise until after busy has been sampled low.
- R10: Only one request is outstanding at a time. No strobe is high while busy is being waited out, and the next strobe rises no earlier than one edge after the release edge.
- R11: When several kinds are pending, they are issued in the order PCS, then CTLE, then DFE.
- R12: A request captured on the same edge that grants the pending request of its kind is kept, and is issued with its own fields after the current handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| autodet_en | input | 1 | Automatic speed detection enabled |
| sel_1g | input | 1 | Static speed select: 1 = 1G, 0 = 10G |
| pcs_req | input | 1 | PCS mode request pulse |
| pcs_use_speed | input | 1 | Derive the data mode from the speed select |
| pcs_mode_in | input | 6 | Requested one-hot PCS mode |
| ctle_req | input | 1 | CTLE request pulse |
| ctle_mode_in | input | 2 | Requested CTLE mode |
| ctle_val_in | input | CTLE_W | Requested CTLE value |
| dfe_req | input | 1 | DFE request pulse |
| dfe_mode_in | input | 2 | Requested DFE mode |
| eng_busy | input | 1 | Busy flag from the reconfiguration engine |
| pcs_start | output | 1 | PCS mode change start strobe |
| pcs_mode_o | output | 6 | One-hot PCS mode to the engine |
| ctle_start | output | 1 | CTLE start strobe |
| ctle_mode_o | output | 2 | CTLE mode to the engine |
| ctle_val_o | output | CTLE_W | CTLE value to the engine |
| dfe_start | output | 1 | DFE start strobe |
| dfe_mode_o | output | 2 | DFE mode to the engine |
| req_err | output | 1 | One-cycle flag for a rejected request |

## Verification
Two events can meet on one clock edge. The first is capturing a new request into a pending slot. The second is the *grant* that empties the same slot. The bench provokes this by pulsing a second CTLE request in the cycle where the first one is granted. It then expects two complete handshakes, the first with the first value and the second with the second value.

The bench also pulses all three kinds in one cycle. It judges the result by the strobe order and by checking that each kind's fields appear only when that kind is granted. Sweeps cover all 64 PCS vectors, all DFE codes and every CTLE mode/value pair.

// File: rtl/xrc_pkg.sv
package xrc_pkg;

    localparam int PCS_W  = 6;
    localparam int MODE_W = 2;

    // bit positions inside the one-hot PCS mode vector
    localparam int PCS_AN  = 0;
    localparam int PCS_LT  = 1;
    localparam int PCS_KR  = 2;
    localparam int PCS_GE  = 3;
    localparam int PCS_RSV = 4;
    localparam int PCS_FEC = 5;

    localparam logic [MODE_W-1:0] DFE_OFF  = 2'b00;
    localparam logic [MODE_W-1:0] DFE_TRIG = 2'b01;
    localparam logic [MODE_W-1:0] CTLE_LT  = 2'b00;

    // request kinds; a lower index wins arbitration
    localparam int N_KIND   = 3;
    localparam int IDX_PCS  = 0;
    localparam int IDX_CTLE = 1;
    localparam int IDX_DFE  = 2;

    localparam logic [PCS_W-1:0] PCS_RESET_CODE = PCS_W'(1) << PCS_AN;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } hs_state_t;

endpackage

// File: rtl/xrc_intake.sv
module xrc_intake
    import xrc_pkg::*;
#(
    parameter int CTLE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     autodet_en,
    input  logic                     sel_1g,
    input  logic                     pcs_req,
    input  logic                     pcs_use_speed,
    input  logic [PCS_W-1:0]         pcs_mode_in,
    input  logic                     ctle_req,
    input  logic [MODE_W-1:0]        ctle_mode_in,
    input  logic [CTLE_W-1:0]        ctle_val_in,
    input  logic                     dfe_req,
    input  logic [MODE_W-1:0]        dfe_mode_in,
    input  logic [N_KIND-1:0]        grant,
    output logic [N_KIND-1:0]        pend,
    output logic [PCS_W-1:0]         pcs_mode_q,
    output logic [MODE_W-1:0]        ctle_mode_q,
    output logic [CTLE_W-1:0]        ctle_val_q,
    output logic [MODE_W-1:0]        dfe_mode_q,
    output logic                     err_o
);

    logic [PCS_W-1:0]  pcs_resolved;
    logic [N_KIND-1:0] req_vec;
    logic [N_KIND-1:0] legal;
    logic [N_KIND-1:0] accept;
    logic [N_KIND-1:0] reject;

    // data-mode resolution from the static speed select
    always_comb begin
        if (pcs_use_speed && !autodet_en) begin
            pcs_resolved = sel_1g ? (PCS_W'(1) << PCS_GE) : (PCS_W'(1) << PCS_KR);
        end else begin
            pcs_resolved = pcs_mode_in;
        end
    end

    always_comb begin
        req_vec            = '0;
        req_vec[IDX_PCS]   = pcs_req;
        req_vec[IDX_CTLE]  = ctle_req;
        req_vec[IDX_DFE]   = dfe_req;
        legal              = '0;
        legal[IDX_PCS]     = $onehot(pcs_resolved) && !pcs_resolved[PCS_RSV];
        legal[IDX_CTLE]    = (ctle_mode_in == CTLE_LT);
        legal[IDX_DFE]     = (dfe_mode_in == DFE_OFF) || (dfe_mode_in == DFE_TRIG);
        accept             = req_vec & legal;
        reject             = req_vec & ~legal;
    end

    // pending slots: a grant empties a slot, a capture on the same edge refills it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= '0;
            err_o <= 1'b0;
        end else begin
            pend  <= (pend & ~grant) | accept;
            err_o <= |reject;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcs_mode_q  <= PCS_RESET_CODE;
            ctle_mode_q <= CTLE_LT;
            ctle_val_q  <= '0;
            dfe_mode_q  <= DFE_OFF;
        end else begin
            if (accept[IDX_PCS]) begin
                pcs_mode_q <= pcs_resolved;
            end
            if (accept[IDX_CTLE]) begin
                ctle_mode_q <= ctle_mode_in;
                ctle_val_q  <= ctle_val_in;
            end
            if (accept[IDX_DFE]) begin
                dfe_mode_q <= dfe_mode_in;
            end
        end
    end

    // R2
    pcs_slot_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend[IDX_PCS] |-> ($onehot(pcs_mode_q) && !pcs_mode_q[PCS_RSV]));

    // R5
    err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !pcs_req && !ctle_req && !dfe_req) |=> !err_o);

endmodule

// File: rtl/xrc_prio_arb.sv
module xrc_prio_arb #(
    parameter int N = 3
) (
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    // lowest index wins
    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (en && req[i] && !seen) begin
                grant[i] = 1'b1;
            end
            seen = seen | req[i];
        end
    end

endmodule

// File: rtl/xrc_hs_fsm.sv
module xrc_hs_fsm
    import xrc_pkg::*;
#(
    parameter int CTLE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     busy,
    input  logic [N_KIND-1:0]        grant,
    input  logic [PCS_W-1:0]         pcs_mode_q,
    input  logic [MODE_W-1:0]        ctle_mode_q,
    input  logic [CTLE_W-1:0]        ctle_val_q,
    input  logic [MODE_W-1:0]        dfe_mode_q,
    output logic                     idle,
    output logic [N_KIND-1:0]        stb,
    output logic [PCS_W-1:0]         pcs_mode_o,
    output logic [MODE_W-1:0]        ctle_mode_o,
    output logic [CTLE_W-1:0]        ctle_val_o,
    output logic [MODE_W-1:0]        dfe_mode_o
);

    hs_state_t         state_q;
    hs_state_t         state_d;
    logic [N_KIND-1:0] kind_q;
    logic              take;

    assign idle = (state_q == ST_IDLE);
    assign take = idle && (|grant);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (|grant) state_d = ST_ISSUE;
            ST_ISSUE: if (busy)   state_d = ST_HOLD;
            ST_HOLD:  if (!busy)  state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                kind_q <= grant;
            end
        end
    end

    // outputs: fields load only on the grant edge of their own kind
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcs_mode_o  <= PCS_RESET_CODE;
            ctle_mode_o <= CTLE_LT;
            ctle_val_o  <= '0;
            dfe_mode_o  <= DFE_OFF;
        end else if (take) begin
            if (grant[IDX_PCS]) begin
                pcs_mode_o <= pcs_mode_q;
            end
            if (grant[IDX_CTLE]) begin
                ctle_mode_o <= ctle_mode_q;
                ctle_val_o  <= ctle_val_q;
            end
            if (grant[IDX_DFE]) begin
                dfe_mode_o <= dfe_mode_q;
            end
        end
    end

    assign stb = (state_q == ST_ISSUE) ? kind_q : '0;

    // R8
    stb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|stb) && busy) |=> !(|stb));

    // R9
    fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(pcs_mode_o) && $stable(ctle_mode_o)
                                  && $stable(ctle_val_o) && $stable(dfe_mode_o)));

    // R10
    single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

    // R2
    pcs_out_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(pcs_mode_o) && !pcs_mode_o[PCS_RSV]);

    // R3
    dfe_out_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dfe_mode_o[1] == 1'b0);

    // R4
    ctle_out_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctle_mode_o == CTLE_LT);

endmodule

// File: rtl/xcvr_reconf_ctrl.sv
module xcvr_reconf_ctrl
    import xrc_pkg::*;
#(
    parameter int CTLE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               autodet_en,
    input  logic               sel_1g,
    input  logic               pcs_req,
    input  logic               pcs_use_speed,
    input  logic [5:0]         pcs_mode_in,
    input  logic               ctle_req,
    input  logic [1:0]         ctle_mode_in,
    input  logic [CTLE_W-1:0]  ctle_val_in,
    input  logic               dfe_req,
    input  logic [1:0]         dfe_mode_in,
    input  logic               eng_busy,
    output logic               pcs_start,
    output logic [5:0]         pcs_mode_o,
    output logic               ctle_start,
    output logic [1:0]         ctle_mode_o,
    output logic [CTLE_W-1:0]  ctle_val_o,
    output logic               dfe_start,
    output logic [1:0]         dfe_mode_o,
    output logic               req_err
);

    logic [N_KIND-1:0] pend;
    logic [N_KIND-1:0] grant;
    logic [N_KIND-1:0] stb;
    logic              idle;
    logic [PCS_W-1:0]  pcs_mode_q;
    logic [MODE_W-1:0] ctle_mode_q;
    logic [CTLE_W-1:0] ctle_val_q;
    logic [MODE_W-1:0] dfe_mode_q;

    xrc_intake #(.CTLE_W(CTLE_W)) u_intake (
        .clk           (clk),
        .rst_n         (rst_n),
        .autodet_en    (autodet_en),
        .sel_1g        (sel_1g),
        .pcs_req       (pcs_req),
        .pcs_use_speed (pcs_use_speed),
        .pcs_mode_in   (pcs_mode_in),
        .ctle_req      (ctle_req),
        .ctle_mode_in  (ctle_mode_in),
        .ctle_val_in   (ctle_val_in),
        .dfe_req       (dfe_req),
        .dfe_mode_in   (dfe_mode_in),
        .grant         (grant),
        .pend          (pend),
        .pcs_mode_q    (pcs_mode_q),
        .ctle_mode_q   (ctle_mode_q),
        .ctle_val_q    (ctle_val_q),
        .dfe_mode_q    (dfe_mode_q),
        .err_o         (req_err)
    );

    xrc_prio_arb #(.N(N_KIND)) u_arb (
        .en    (idle),
        .req   (pend),
        .grant (grant)
    );

    xrc_hs_fsm #(.CTLE_W(CTLE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (eng_busy),
        .grant       (grant),
        .pcs_mode_q  (pcs_mode_q),
        .ctle_mode_q (ctle_mode_q),
        .ctle_val_q  (ctle_val_q),
        .dfe_mode_q  (dfe_mode_q),
        .idle        (idle),
        .stb         (stb),
        .pcs_mode_o  (pcs_mode_o),
        .ctle_mode_o (ctle_mode_o),
        .ctle_val_o  (ctle_val_o),
        .dfe_mode_o  (dfe_mode_o)
    );

    assign pcs_start  = stb[IDX_PCS];
    assign ctle_start = stb[IDX_CTLE];
    assign dfe_start  = stb[IDX_DFE];

    // R11
    prio_dfe_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dfe_start) |-> $past(!pend[IDX_PCS] && !pend[IDX_CTLE]));

endmodule

// File: tb/test_xcvr_reconf_ctrl.sv
module test_xcvr_reconf_ctrl;

    localparam time CLK_P = 10ns;
    localparam int  CW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          autodet_en = 1'b1;
    logic          sel_1g = 1'b0;
    logic          pcs_req = 1'b0;
    logic          pcs_use_speed = 1'b0;
    logic [5:0]    pcs_mode_in = '0;
    logic          ctle_req = 1'b0;
    logic [1:0]    ctle_mode_in = '0;
    logic [CW-1:0] ctle_val_in = '0;
    logic          dfe_req = 1'b0;
    logic [1:0]    dfe_mode_in = '0;
    logic          eng_busy = 1'b0;
    logic          pcs_start, ctle_start, dfe_start, req_err;
    logic [5:0]    pcs_mode_o;
    logic [1:0]    ctle_mode_o, dfe_mode_o;
    logic [CW-1:0] ctle_val_o;

    int total = 0;
    int bad   = 0;

    logic [5:0]    sh_pcs = 6'b000001;
    logic [1:0]    sh_cm  = 2'b00;
    logic [CW-1:0] sh_cv  = '0;
    logic [1:0]    sh_dfe = 2'b00;

    wire [2:0] stb = {dfe_start, ctle_start, pcs_start};

    always #(CLK_P/2) clk = ~clk;

    xcvr_reconf_ctrl #(.CTLE_W(CW)) i_xcvr_reconf_ctrl (
        .clk(clk), .rst_n(rst_n), .autodet_en(autodet_en), .sel_1g(sel_1g),
        .pcs_req(pcs_req), .pcs_use_speed(pcs_use_speed), .pcs_mode_in(pcs_mode_in),
        .ctle_req(ctle_req), .ctle_mode_in(ctle_mode_in), .ctle_val_in(ctle_val_in),
        .dfe_req(dfe_req), .dfe_mode_in(dfe_mode_in), .eng_busy(eng_busy),
        .pcs_start(pcs_start), .pcs_mode_o(pcs_mode_o), .ctle_start(ctle_start),
        .ctle_mode_o(ctle_mode_o), .ctle_val_o(ctle_val_o), .dfe_start(dfe_start),
        .dfe_mode_o(dfe_mode_o), .req_err(req_err)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(bit ok, string rq, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic chk_fields(string rq);
        check(pcs_mode_o == sh_pcs, rq, "pcs_mode_o", pcs_mode_o, sh_pcs);
        check(ctle_mode_o == sh_cm, rq, "ctle_mode_o", ctle_mode_o, sh_cm);
        check(ctle_val_o == sh_cv, rq, "ctle_val_o", ctle_val_o, sh_cv);
        check(dfe_mode_o == sh_dfe, rq, "dfe_mode_o", dfe_mode_o, sh_dfe);
    endtask

    // called at the negedge where strobe k must be high
    task automatic serve(int k, string rq);
        logic [2:0] want;
        want = 3'b001 << k;
        check(stb == want, rq, "strobe at grant", stb, want);
        chk_fields(rq);
        repeat (2) tick();
        check(stb == want, "R8", "strobe held without busy", stb, want);
        eng_busy = 1'b1;
        tick();
        check(stb == 3'b000, "R8", "strobe after busy", stb, 0);
        chk_fields("R9");
        tick();
        tick();
        eng_busy = 1'b0;
        chk_fields("R9");
        tick();
        check(stb == 3'b000, "R10", "no strobe on release edge", stb, 0);
        chk_fields("R9");
    endtask

    // k: 0 PCS, 1 CTLE, 2 DFE
    task automatic one_req(int k, logic [5:0] pm, bit use_spd, logic [1:0] md,
                           logic [CW-1:0] cv, string tag);
        logic [5:0] res;
        bit ok;
        res = pm;
        ok  = 1'b0;
        if (k == 0) begin
            if (use_spd && !autodet_en) res = sel_1g ? 6'b001000 : 6'b000100;
            ok = ($countones(res) == 1) && !res[4];
            pcs_mode_in = pm; pcs_use_speed = use_spd; pcs_req = 1'b1;
        end else if (k == 1) begin
            ok = (md == 2'b00);
            ctle_mode_in = md; ctle_val_in = cv; ctle_req = 1'b1;
        end else begin
            ok = (md < 2'd2);
            dfe_mode_in = md; dfe_req = 1'b1;
        end
        tick();
        pcs_req = 1'b0; ctle_req = 1'b0; dfe_req = 1'b0; pcs_use_speed = 1'b0;
        check(req_err == !ok, ok ? tag : "R5", "req_err after capture", req_err, !ok);
        check(stb == 3'b000, "R7", "no strobe one edge after request", stb, 0);
        if (ok) begin
            if (k == 0) sh_pcs = res;
            else if (k == 1) begin sh_cm = md; sh_cv = cv; end
            else sh_dfe = md;
            tick();
            serve(k, ok ? tag : "R7");
        end else begin
            tick();
            check(req_err == 1'b0, "R5", "req_err width", req_err, 0);
            check(stb == 3'b000, "R5", "no strobe on reject", stb, 0);
            chk_fields({"R5 ", tag});
            tick();
            check(stb == 3'b000, "R5", "still no strobe", stb, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(stb == 3'b000, "R1", "strobes", stb, 0);
        check(req_err == 1'b0, "R1", "req_err", req_err, 0);
        chk_fields("R1");

        // R2 full sweep of PCS vectors
        autodet_en = 1'b1;
        for (int v = 0; v < 64; v++) one_req(0, 6'(v), 1'b0, 2'b00, '0, "R2");

        // R6 data mode resolution
        autodet_en = 1'b0; sel_1g = 1'b1;
        one_req(0, 6'b000000, 1'b1, 2'b00, '0, "R6");
        sel_1g = 1'b0;
        one_req(0, 6'b010000, 1'b1, 2'b00, '0, "R6");
        autodet_en = 1'b1; sel_1g = 1'b1;
        one_req(0, 6'b100000, 1'b1, 2'b00, '0, "R6");
        one_req(0, 6'b010000, 1'b1, 2'b00, '0, "R6");
        autodet_en = 1'b0;
        one_req(0, 6'b000010, 1'b0, 2'b00, '0, "R6");

        // R3 DFE codes
        for (int m = 0; m < 4; m++) one_req(2, '0, 1'b0, 2'(m), '0, "R3");
        // R4 CTLE mode and value sweep
        for (int m = 0; m < 4; m++)
            for (int v = 0; v < 16; v++) one_req(1, '0, 1'b0, 2'(m), CW'(v), "R4");

        // R11 all three kinds in one cycle
        pcs_mode_in = 6'b000010; pcs_req = 1'b1;
        ctle_mode_in = 2'b00; ctle_val_in = 4'hA; ctle_req = 1'b1;
        dfe_mode_in = 2'b01; dfe_req = 1'b1;
        tick();
        pcs_req = 1'b0; ctle_req = 1'b0; dfe_req = 1'b0;
        check(req_err == 1'b0, "R11", "burst accepted", req_err, 0);
        tick();
        sh_pcs = 6'b000010;
        serve(0, "R11");
        tick();
        sh_cm = 2'b00; sh_cv = 4'hA;
        serve(1, "R11");
        tick();
        sh_dfe = 2'b01;
        serve(2, "R11");

        // R12 same-kind request on the grant edge
        ctle_mode_in = 2'b00; ctle_val_in = 4'h3; ctle_req = 1'b1;
        tick();
        ctle_val_in = 4'h9;
        tick();
        ctle_req = 1'b0;
        sh_cv = 4'h3;
        serve(1, "R12");
        tick();
        sh_cv = 4'h9;
        serve(1, "R12");
        repeat (3) tick();
        check(stb == 3'b000, "R12", "no third handshake", stb, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule